// File: doc/BRIEF.md
# Write-Update Snoop Coherence Controller

This block keeps one cache coherent with its peers on a snooping bus that uses a write-update policy. Every line held in the cache is in one of four valid states. Dirty (D) and shared-dirty (SD) are owner states. Valid-exclusive (VE) and shared-clean (SC) are non-owner states. A line that is not held is simply a tag miss, so there is no invalid state. The cache is direct mapped and holds one data word per line. The low `IDX_W` address bits select the set, and the remaining bits form the tag.

The processor side issues reads and writes and holds `cpu_req` until it sees `cpu_done`. On the bus side, the controller issues bus reads, single-word update broadcasts and write-backs of evicted dirty lines. It samples the wired-OR shared line and fill data from the other caches (or memory) in the cycle that follows each of its own commands. It also watches read and update transactions from other caches. In the cycle after a snooped transaction hits a line, it asserts its own shared output. When it holds an owner state for that line, it also supplies the line's data. Writes to shared lines are broadcast to the peers and are never written to memory. Memory is written only when a D or SD line is evicted.

Top module: `wu_coh_ctrl`

## Requirements
- R1: A processor read miss places a READ command (op 2'b01) for the requested address on the bus in the cycle after acceptance. In the cycle after that, the controller samples `bus_shared_in` and `bus_fill_data`. One cycle later it raises `cpu_done` with `cpu_rdata` equal to the fill word.
- R2: After a fill, the line is SC if `bus_shared_in` was high in the sampling cycle and VE otherwise. A later write hit on an SC line therefore broadcasts, and a later write hit on a VE line does not.
- R3: A processor write hit on a D or VE line stores the word and leaves the line in D. It issues no bus command, and `cpu_done` rises in the cycle after acceptance.
- R4: A processor write hit on an SD or SC line issues an UPDATE command (op 2'b10) carrying the address and the new word in the cycle after acceptance. The line becomes SD if `bus_shared_in` is high in the following cycle and D otherwise. `cpu_done` rises one cycle after that.
- R5: A processor write miss first performs the R1 fill sequence and then stores the new word. If the fill sampled the shared line high, an UPDATE with the new word follows at once and the line ends in SD. Otherwise there is no UPDATE and the line ends in D.
- R6: A snooped READ (op 2'b01) that hits raises `snp_shared` in the next cycle. If the line is D or SD, `snp_supply` is also raised with `snp_supply_data` equal to the stored word, and the line becomes SD. If the line is VE or SC, there is no supply and the line becomes SC.
- R7: A snooped UPDATE (op 2'b10) that hits stores the broadcast word, leaves the line in SC and raises `snp_shared` without `snp_supply` in the next cycle.
- R8: A snooped transaction that misses changes nothing and produces neither `snp_shared` nor `snp_supply`. These two outputs are low in every cycle that does not follow a snooped transaction.
- R9: A miss to a set whose resident line is D or SD first issues a WRBACK command (op 2'b11) with the victim's address and word, and the READ follows in the next cycle. A resident VE or SC line is replaced without any write-back. An evicted line no longer answers snoops.
- R10: Reset clears every line's present bit and drives `cpu_done`, `bus_cmd_valid`, `snp_shared` and `snp_supply` low.
- R11: A processor request is not accepted in a cycle in which `snp_valid` is high. The snooped transaction takes effect first, and the request is accepted in a later cycle against the updated line.
- R12: A processor read hit returns the stored word with `cpu_done` in the cycle after acceptance and issues no bus command. `cpu_done` is a single-cycle pulse, and no request is accepted in the cycle that `cpu_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` on reads |
| bus_cmd_valid | output | 1 | Bus command issued this cycle |
| bus_cmd_op | output | 2 | 01 read, 10 update, 11 write-back |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_data | output | DATA_W | Update or write-back word |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| bus_fill_data | input | DATA_W | Fill word from the owner cache or memory |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_op | input | 2 | 01 read, 10 update; other codes ignored |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped update word |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_supply_data | output | DATA_W | Intervention data |

## Verification
A read hit or a local write completes with `cpu_done` one cycle after acceptance. A bus command appears one cycle after acceptance (or one cycle after a write-back). The shared line and fill are sampled in the following cycle, and `cpu_done` follows one cycle later. Snoop responses are due exactly one cycle after the snooped transaction. The bench drives inputs on falling edges and lets a scoreboard monitor compare every bus command and every completion, on the falling edge of the cycle where each is due, against expectations queued in order. A bus responder holds the shared line and fill word from the falling edge that shows a command until the edge on which the controller samples them. Snoop responses are sampled one falling edge after the snoop is driven. Line states are never read directly: each one is inferred from the next command or snoop response it causes.

// File: rtl/wu_coh_pkg.sv
package wu_coh_pkg;

    // line state, 2-bit field per tag entry
    typedef enum logic [1:0] {
        LN_SC = 2'b00,
        LN_VE = 2'b01,
        LN_SD = 2'b10,
        LN_D  = 2'b11
    } line_st_t;

    // shared encoding for issued commands and snooped transactions
    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_READ   = 2'b01,
        OP_UPDATE = 2'b10,
        OP_WRBACK = 2'b11
    } bus_op_t;

    typedef enum logic [2:0] {
        F_IDLE    = 3'd0,
        F_WB      = 3'd1,
        F_RD      = 3'd2,
        F_RD_RSP  = 3'd3,
        F_UPD     = 3'd4,
        F_UPD_RSP = 3'd5
    } fsm_t;

    function automatic logic is_owner(line_st_t s);
        return (s == LN_D) || (s == LN_SD);
    endfunction

endpackage

// File: rtl/wu_tag_match.sv
module wu_tag_match #(
    parameter int TAG_W = 13
) (
    input  logic             present,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = present && (stored_tag == req_tag);
endmodule

// File: rtl/wu_snoop_policy.sv
module wu_snoop_policy
    import wu_coh_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              hit,
    input  logic [1:0]        op,
    input  line_st_t          cur_st,
    input  logic [DATA_W-1:0] cur_data,
    input  logic [DATA_W-1:0] upd_data,
    output logic              wr_en,
    output line_st_t          new_st,
    output logic [DATA_W-1:0] new_data,
    output logic              shared,
    output logic              supply
);
    always_comb begin
        wr_en    = 1'b0;
        new_st   = cur_st;
        new_data = cur_data;
        shared   = 1'b0;
        supply   = 1'b0;
        if (hit) begin
            case (bus_op_t'(op))
                OP_READ: begin
                    wr_en  = 1'b1;
                    shared = 1'b1;
                    if (is_owner(cur_st)) begin
                        supply = 1'b1;
                        new_st = LN_SD;
                    end else begin
                        new_st = LN_SC;
                    end
                end
                OP_UPDATE: begin
                    wr_en    = 1'b1;
                    shared   = 1'b1;
                    new_st   = LN_SC;
                    new_data = upd_data;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wu_coh_ctrl.sv
module wu_coh_ctrl
    import wu_coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_cmd_valid,
    output logic [1:0]        bus_cmd_op,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_data,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_supply_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int NPORT = 2;   // port 0: processor, port 1: snoop

    typedef struct packed {
        fsm_t                        fsm;
        logic [SETS-1:0]             present;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][1:0]        st;
        logic [SETS-1:0][DATA_W-1:0] data;
        logic                        we;
        logic [ADDR_W-1:0]           addr;
        logic [DATA_W-1:0]           wdata;
        logic                        done;
        logic [DATA_W-1:0]           rdata;
        logic                        shr;
        logic                        sup;
        logic [DATA_W-1:0]           sdata;
    } regs_t;

    regs_t r_q, r_d;

    // tag lookups for both ports
    logic [NPORT-1:0][ADDR_W-1:0] m_addr;
    logic [NPORT-1:0][IDX_W-1:0]  m_idx;
    logic [NPORT-1:0][TAG_W-1:0]  m_tag;
    logic [NPORT-1:0]             m_hit;

    assign m_addr[0] = (r_q.fsm == F_IDLE) ? cpu_addr : r_q.addr;
    assign m_addr[1] = snp_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_match
        assign m_idx[p] = m_addr[p][IDX_W-1:0];
        assign m_tag[p] = m_addr[p][ADDR_W-1:IDX_W];
        wu_tag_match #(.TAG_W(TAG_W)) u_match (
            .present    (r_q.present[m_idx[p]]),
            .stored_tag (r_q.tag[m_idx[p]]),
            .req_tag    (m_tag[p]),
            .hit        (m_hit[p])
        );
    end

    // snoop policy
    logic              pol_wr, pol_shr, pol_sup;
    line_st_t          pol_st;
    logic [DATA_W-1:0] pol_data;
    logic [IDX_W-1:0]  sidx;

    assign sidx = m_idx[1];

    wu_snoop_policy #(.DATA_W(DATA_W)) u_snoop (
        .hit      (snp_valid && m_hit[1]),
        .op       (snp_op),
        .cur_st   (line_st_t'(r_q.st[sidx])),
        .cur_data (r_q.data[sidx]),
        .upd_data (snp_data),
        .wr_en    (pol_wr),
        .new_st   (pol_st),
        .new_data (pol_data),
        .shared   (pol_shr),
        .supply   (pol_sup)
    );

    logic [IDX_W-1:0] cidx, lidx;
    line_st_t         cst;
    assign cidx = m_idx[0];
    assign lidx = r_q.addr[IDX_W-1:0];
    assign cst  = line_st_t'(r_q.st[cidx]);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;

        // snoop side first; processor side may override below
        r_d.shr   = pol_shr;
        r_d.sup   = pol_sup;
        r_d.sdata = pol_sup ? r_q.data[sidx] : '0;
        if (pol_wr) begin
            r_d.st[sidx]   = pol_st;
            r_d.data[sidx] = pol_data;
        end

        case (r_q.fsm)
            F_IDLE: begin
                if (cpu_req && !snp_valid && !r_q.done) begin
                    r_d.we    = cpu_we;
                    r_d.addr  = cpu_addr;
                    r_d.wdata = cpu_wdata;
                    if (m_hit[0]) begin
                        if (!cpu_we) begin
                            r_d.done  = 1'b1;
                            r_d.rdata = r_q.data[cidx];
                        end else if (cst == LN_D || cst == LN_VE) begin
                            r_d.data[cidx] = cpu_wdata;
                            r_d.st[cidx]   = LN_D;
                            r_d.done       = 1'b1;
                        end else begin
                            r_d.fsm = F_UPD;
                        end
                    end else if (r_q.present[cidx] && is_owner(cst)) begin
                        r_d.fsm = F_WB;
                    end else begin
                        r_d.fsm = F_RD;
                    end
                end
            end
            F_WB: r_d.fsm = F_RD;
            F_RD: r_d.fsm = F_RD_RSP;
            F_RD_RSP: begin
                r_d.present[lidx] = 1'b1;
                r_d.tag[lidx]     = r_q.addr[ADDR_W-1:IDX_W];
                if (!r_q.we) begin
                    r_d.data[lidx] = bus_fill_data;
                    r_d.st[lidx]   = bus_shared_in ? LN_SC : LN_VE;
                    r_d.rdata      = bus_fill_data;
                    r_d.done       = 1'b1;
                    r_d.fsm        = F_IDLE;
                end else if (bus_shared_in) begin
                    r_d.data[lidx] = r_q.wdata;
                    r_d.st[lidx]   = LN_SC;
                    r_d.fsm        = F_UPD;
                end else begin
                    r_d.data[lidx] = r_q.wdata;
                    r_d.st[lidx]   = LN_D;
                    r_d.done       = 1'b1;
                    r_d.fsm        = F_IDLE;
                end
            end
            F_UPD: r_d.fsm = F_UPD_RSP;
            F_UPD_RSP: begin
                r_d.data[lidx] = r_q.wdata;
                r_d.st[lidx]   = bus_shared_in ? LN_SD : LN_D;
                r_d.done       = 1'b1;
                r_d.fsm        = F_IDLE;
            end
            default: r_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // outputs
    always_comb begin
        bus_cmd_valid = 1'b0;
        bus_cmd_op    = OP_NONE;
        bus_cmd_addr  = r_q.addr;
        bus_cmd_data  = '0;
        case (r_q.fsm)
            F_WB: begin
                bus_cmd_valid = 1'b1;
                bus_cmd_op    = OP_WRBACK;
                bus_cmd_addr  = {r_q.tag[lidx], lidx};
                bus_cmd_data  = r_q.data[lidx];
            end
            F_RD: begin
                bus_cmd_valid = 1'b1;
                bus_cmd_op    = OP_READ;
            end
            F_UPD: begin
                bus_cmd_valid = 1'b1;
                bus_cmd_op    = OP_UPDATE;
                bus_cmd_data  = r_q.wdata;
            end
            default: ;
        endcase
    end

    assign cpu_done        = r_q.done;
    assign cpu_rdata       = r_q.rdata;
    assign snp_shared      = r_q.shr;
    assign snp_supply      = r_q.sup;
    assign snp_supply_data = r_q.sdata;

endmodule

// File: rtl/wu_coh_ctrl_chk.sv
module wu_coh_ctrl_chk
    import wu_coh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_done,
    input logic       snp_valid,
    input logic [1:0] snp_op,
    input logic       snp_shared,
    input logic       snp_supply,
    input logic       bus_cmd_valid,
    input logic [1:0] bus_cmd_op
);
    p_supply_needs_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);

    p_update_no_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_op == OP_UPDATE) |=> !snp_supply);

    p_quiet_without_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> (!snp_shared && !snp_supply));

    p_read_then_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op == OP_READ) |=> !bus_cmd_valid);

    p_wrback_then_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op == OP_WRBACK) |=> (bus_cmd_valid && bus_cmd_op == OP_READ));

    p_update_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_cmd_op == OP_UPDATE) |=> ##1 cpu_done);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    p_op_coded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> (bus_cmd_op != OP_NONE));
endmodule

bind wu_coh_ctrl wu_coh_ctrl_chk chk_i (.*);

// File: tb/wu_coh_ctrl_tb_top.sv
module wu_coh_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [1:0] RD = 2'b01, UP = 2'b10, WB = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_cmd_valid;
    logic [1:0]    bus_cmd_op;
    logic [AW-1:0] bus_cmd_addr;
    logic [DW-1:0] bus_cmd_data;
    logic          bus_shared_in = 1'b0;
    logic [DW-1:0] bus_fill_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared, snp_supply;
    logic [DW-1:0] snp_supply_data;

    always #5 clk = ~clk;

    wu_coh_ctrl dut_i (.*);

    int checks = 0;
    int failures = 0;

    typedef struct { logic [1:0] op; logic [AW-1:0] addr; logic [DW-1:0] data; logic chk; string req; } bus_exp_t;
    typedef struct { logic [DW-1:0] data; logic chk; string req; } cpu_exp_t;
    bus_exp_t exp_bus[$];
    cpu_exp_t exp_cpu[$];

    // responder values the driver selects for the next transaction
    logic          resp_shared = 1'b0;
    logic [DW-1:0] resp_fill = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic push_bus(input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic c, input string req);
        bus_exp_t e;
        e.op = op; e.addr = a; e.data = d; e.chk = c; e.req = req;
        exp_bus.push_back(e);
    endtask

    task automatic push_cpu(input logic [DW-1:0] d, input logic c, input string req);
        cpu_exp_t e;
        e.data = d; e.chk = c; e.req = req;
        exp_cpu.push_back(e);
    endtask

    // bus responder: holds shared/fill from the command cycle through the sampling edge
    int hold = 0;
    always @(negedge clk) begin
        if (hold > 0) begin
            hold--;
            if (hold == 0) begin
                bus_shared_in = 1'b0;
                bus_fill_data = '0;
            end
        end
        if (rst_n && bus_cmd_valid && (bus_cmd_op == RD || bus_cmd_op == UP)) begin
            bus_shared_in = resp_shared;
            bus_fill_data = resp_fill;
            hold = 2;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_cmd_valid) begin
                if (exp_bus.size() == 0) begin
                    chk(1'b0, "R3", "unexpected bus command", {30'd0, bus_cmd_op}, '0);
                end else begin
                    bus_exp_t e;
                    e = exp_bus.pop_front();
                    chk(bus_cmd_op == e.op, e.req, "bus op", {30'd0, bus_cmd_op}, {30'd0, e.op});
                    chk(bus_cmd_addr == e.addr, e.req, "bus addr", {16'd0, bus_cmd_addr}, {16'd0, e.addr});
                    if (e.chk) chk(bus_cmd_data == e.data, e.req, "bus data", bus_cmd_data, e.data);
                end
            end
            if (cpu_done) begin
                if (exp_cpu.size() == 0) begin
                    chk(1'b0, "R12", "unexpected done", cpu_rdata, '0);
                end else begin
                    cpu_exp_t c;
                    c = exp_cpu.pop_front();
                    if (c.chk) chk(cpu_rdata == c.data, c.req, "rdata", cpu_rdata, c.data);
                end
            end
        end
    end

    task automatic cpu_access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                              input logic oth_shared, input logic [DW-1:0] fill);
        resp_shared = oth_shared;
        resp_fill   = fill;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cpu_done) break;
        end
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic e_shr, input logic e_sup, input logic [DW-1:0] e_dat,
                         input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a; snp_data = d;
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'b00;
        chk(snp_shared == e_shr, req, "snp_shared", {31'd0, snp_shared}, {31'd0, e_shr});
        chk(snp_supply == e_sup, req, "snp_supply", {31'd0, snp_supply}, {31'd0, e_sup});
        if (e_sup) chk(snp_supply_data == e_dat, req, "snp_supply_data", snp_supply_data, e_dat);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got %0d expected 0", 1);
        finish_run();
    end

    localparam logic [AW-1:0] A = 16'h0010, B = 16'h0021, C = 16'h0018, D = 16'h0008;
    localparam logic [AW-1:0] E = 16'h0003, F = 16'h0045, G = 16'h0029;

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!cpu_done && !bus_cmd_valid, "R10", "reset done/cmd", {31'd0, cpu_done | bus_cmd_valid}, '0);
        chk(!snp_shared && !snp_supply, "R10", "reset snoop", {31'd0, snp_shared | snp_supply}, '0);
        snoop(RD, A, 0, 0, 0, 0, "R10");

        // R1 read miss, no sharer -> VE
        push_bus(RD, A, 0, 0, "R1");
        push_cpu(32'h1111_1111, 1, "R1");
        cpu_access(0, A, 0, 0, 32'h1111_1111);
        snoop(RD, A, 0, 1, 0, 0, "R6");            // VE -> SC, no supply

        // R4 write hit SC, sharer present -> SD
        push_bus(UP, A, 32'h2222_2222, 1, "R4");
        push_cpu(0, 0, "R4");
        cpu_access(1, A, 32'h2222_2222, 1, 0);
        snoop(RD, A, 0, 1, 1, 32'h2222_2222, "R6");

        // R12 read hit
        push_cpu(32'h2222_2222, 1, "R12");
        cpu_access(0, A, 0, 0, 0);

        // R4 write hit SD, no sharer -> D
        push_bus(UP, A, 32'h3333_3333, 1, "R4");
        push_cpu(0, 0, "R4");
        cpu_access(1, A, 32'h3333_3333, 0, 0);
        // R3 write hit D: local
        push_cpu(0, 0, "R3");
        cpu_access(1, A, 32'h4444_4444, 0, 0);
        snoop(RD, A, 0, 1, 1, 32'h4444_4444, "R3");
        push_bus(UP, A, 32'h5555_5555, 1, "R4");
        push_cpu(0, 0, "R4");
        cpu_access(1, A, 32'h5555_5555, 0, 0);

        // R2 VE fill then R3 write hit VE local
        push_bus(RD, B, 0, 0, "R2");
        push_cpu(32'h0000_00B0, 1, "R2");
        cpu_access(0, B, 0, 0, 32'h0000_00B0);
        push_cpu(0, 0, "R3");
        cpu_access(1, B, 32'h0000_00B1, 0, 0);
        snoop(RD, B, 0, 1, 1, 32'h0000_00B1, "R3");

        // R7 snooped update
        snoop(UP, B, 32'h0000_00BB, 1, 0, 0, "R7");
        push_cpu(32'h0000_00BB, 1, "R7");
        cpu_access(0, B, 0, 0, 0);
        snoop(RD, B, 0, 1, 0, 0, "R7");

        // R8 snoop misses
        snoop(UP, F, 32'h99, 0, 0, 0, "R8");
        snoop(RD, F, 0, 0, 0, 0, "R8");

        // R9 dirty eviction of A (D) by C; fill shared -> SC
        push_bus(WB, A, 32'h5555_5555, 1, "R9");
        push_bus(RD, C, 0, 0, "R9");
        push_cpu(32'h0000_00C0, 1, "R2");
        cpu_access(0, C, 0, 1, 32'h0000_00C0);
        snoop(RD, A, 0, 0, 0, 0, "R9");
        push_bus(UP, C, 32'h0000_00C1, 1, "R2");   // SC write hit broadcasts
        push_cpu(0, 0, "R2");
        cpu_access(1, C, 32'h0000_00C1, 1, 0);

        // R9 silent eviction of B (SC), R5 write miss shared -> SD
        push_bus(RD, G, 0, 0, "R9");
        push_bus(UP, G, 32'h0000_00D1, 1, "R5");
        push_cpu(0, 0, "R5");
        cpu_access(1, G, 32'h0000_00D1, 1, 32'h70);
        snoop(RD, G, 0, 1, 1, 32'h0000_00D1, "R5");
        snoop(RD, B, 0, 0, 0, 0, "R9");

        // R9 SD victim C written back; R5 write miss unshared -> D
        push_bus(WB, C, 32'h0000_00C1, 1, "R9");
        push_bus(RD, D, 0, 0, "R5");
        push_cpu(0, 0, "R5");
        cpu_access(1, D, 32'h0000_00DD, 0, 32'h0000_00D0);
        snoop(RD, D, 0, 1, 1, 32'h0000_00DD, "R5");

        push_bus(RD, E, 0, 0, "R5");
        push_cpu(0, 0, "R5");
        cpu_access(1, E, 32'h0000_00E1, 0, 32'h0000_00E0);
        snoop(RD, E, 0, 1, 1, 32'h0000_00E1, "R5");

        // R11 snoop update and processor write in the same cycle
        push_bus(UP, E, 32'h0000_0077, 1, "R11");
        push_cpu(0, 0, "R11");
        fork
            cpu_access(1, E, 32'h0000_0077, 1, 0);
            snoop(UP, E, 32'h0000_0066, 1, 0, 0, "R11");
        join
        snoop(RD, E, 0, 1, 1, 32'h0000_0077, "R11");

        repeat (3) @(negedge clk);
        chk(exp_bus.size() == 0, "R1", "bus queue left", exp_bus.size(), 0);
        chk(exp_cpu.size() == 0, "R12", "cpu queue left", exp_cpu.size(), 0);
        finish_run();
    end
endmodule